// File: doc/BRIEF.md
# Carry-Chain Integer Add/Subtract Unit

A 64-bit fixed-point adder/subtractor for an integer execution pipe. One carry chain serves every operation: the unit picks the two adder inputs and the carry-in from the opcode. Subtract forms invert operand A and inject a carry, so "subtract from" gives B - A. Extended forms take their carry-in from the stored carry bit or from the overflow bit. Immediate forms sign-extend a 16-bit value, optionally shifted up by 16 bits. A zero register-index flag turns operand A into a literal zero. One form adds the shifted immediate to the next instruction address.

The result, the carry-out, the overflow bit and a four-bit condition field are combinational in the cycle the operands are presented. The only state is the sticky summary-overflow bit. It is set at the clock edge of an issued operation that records a signed overflow, and it is cleared only by reset.

Top module: `add_sub_unit`

## Requirements
- R1: Opcodes: ADD=0 gives A+B, SUBF=1 gives ~A+B+1, ADDC=2 gives A+B, SUBFC=3 gives ~A+B+1, NEG=10 gives ~A+1, SUBFIC=16 gives ~A+sext(imm)+1, ADDIC=14 and ADDIC_REC=15 give A+sext(imm). All arithmetic is modulo 2^64.
- R2: ADDI=11 gives sext(imm), or A+sext(imm) when ra_zero_i=0. ADDIS=12 does the same with sext({imm,16'h0}). The zero-index rule applies only to these two opcodes.
- R3: ADDPCIS=13 gives nia_i + sext({imm,16'h0}).
- R4: The extended forms use ca_i as carry-in: ADDE=4 is A+B+ca, SUBFE=5 is ~A+B+ca, ADDME=6 is A+all-ones+ca, SUBFME=7 is ~A+all-ones+ca, ADDZE=8 is A+ca, SUBFZE=9 is ~A+ca.
- R5: ca_o is the adder carry-out for opcodes 2-9 and 14-16. For every other opcode ca_o equals ca_i.
- R6: ADDEX=17 computes A+B+ov_i, drives the carry-out on ov_o, and passes ca_i to ca_o unchanged.
- R7: On opcodes 0-10 with oe_i=1, ov_o is signed overflow: both adder inputs share a sign and the result sign differs. In every other case except ADDEX, ov_o equals ov_i.
- R8: so_o is 0 after reset. It becomes 1 at the clock edge after exec_i=1 on opcodes 0-10 with oe_i=1 and signed overflow. It then stays 1 until reset.
- R9: On opcodes 0-10 with rc_i=1, and always on ADDIC_REC, cond_o = {lt, gt, eq, so}. lt, gt and eq compare the signed result with zero. so is so_o OR this operation's recorded overflow. In all other cases cond_o is 0.
- R10: Unassigned opcodes (18-31) give res_o=0, ca_o=ca_i, ov_o=ov_i and cond_o=0, and never set so_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Operation issued this cycle (qualifies sticky update) |
| op_i | input | 5 | Opcode |
| oe_i | input | 1 | Overflow-record enable |
| rc_i | input | 1 | Condition-record enable |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| imm_i | input | 16 | Signed immediate |
| ra_zero_i | input | 1 | A register index is zero |
| nia_i | input | 64 | Next instruction address |
| ca_i | input | 1 | Stored carry |
| ov_i | input | 1 | Stored overflow (alternate carry) |
| res_o | output | 64 | Result |
| ca_o | output | 1 | New carry |
| ov_o | output | 1 | New overflow |
| so_o | output | 1 | Sticky summary overflow |
| cond_o | output | 4 | {lt, gt, eq, so} condition field |

## Verification
Two functions can act in the same cycle. An overflowing operation with both oe_i and rc_i set must report the fresh overflow in the condition field's so bit before the sticky register has taken it. The bench provokes this with a 0x7FFF_FFFF_FFFF_FFFF + 1 add with both enables set. It checks that cond_o[0] is already 1 while so_o is still 0, and that so_o rises one edge later. A later overflow-free operation must then show so_o held and cond_o[0] still set.

// File: rtl/add_sub_pkg.sv
package add_sub_pkg;
  localparam int XLEN  = 64;
  localparam int IMM_W = 16;

  typedef enum logic [4:0] {
    OP_ADD      = 5'd0,
    OP_SUBF     = 5'd1,
    OP_ADDC     = 5'd2,
    OP_SUBFC    = 5'd3,
    OP_ADDE     = 5'd4,
    OP_SUBFE    = 5'd5,
    OP_ADDME    = 5'd6,
    OP_SUBFME   = 5'd7,
    OP_ADDZE    = 5'd8,
    OP_SUBFZE   = 5'd9,
    OP_NEG      = 5'd10,
    OP_ADDI     = 5'd11,
    OP_ADDIS    = 5'd12,
    OP_ADDPCIS  = 5'd13,
    OP_ADDIC    = 5'd14,
    OP_ADDIC_RC = 5'd15,
    OP_SUBFIC   = 5'd16,
    OP_ADDEX    = 5'd17
  } op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_CA, CIN_OV} cin_e;

  // register forms honour oe/rc
  function automatic logic is_reg_form(op_e op);
    return op inside {[OP_ADD:OP_NEG]};
  endfunction

  function automatic logic writes_ca(op_e op);
    return op inside {[OP_ADDC:OP_SUBFZE], OP_ADDIC, OP_ADDIC_RC, OP_SUBFIC};
  endfunction
endpackage

// File: rtl/add_sub_opsel.sv
module add_sub_opsel
  import add_sub_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMM_W
) (
  input  op_e           op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [IW-1:0] imm_i,
  input  logic          ra_zero_i,
  input  logic [W-1:0]  nia_i,
  input  logic          ca_i,
  input  logic          ov_i,
  output logic [W-1:0]  x_o,
  output logic [W-1:0]  y_o,
  output logic          cin_o,
  output logic          legal_o
);
  localparam int SH_EXT = W - 2*IW;

  logic [W-1:0] imm_sx, imm_sh, a_or_zero;
  cin_e         cin_sel;

  assign imm_sx    = {{(W-IW){imm_i[IW-1]}}, imm_i};
  assign imm_sh    = {{SH_EXT{imm_i[IW-1]}}, imm_i, {IW{1'b0}}};
  assign a_or_zero = ra_zero_i ? '0 : a_i;

  always_comb begin
    x_o     = a_i;
    y_o     = b_i;
    cin_sel = CIN_ZERO;
    legal_o = 1'b1;
    unique case (op_i)
      OP_ADD, OP_ADDC:          ;
      OP_SUBF, OP_SUBFC:        begin x_o = ~a_i; cin_sel = CIN_ONE; end
      OP_ADDE:                  cin_sel = CIN_CA;
      OP_SUBFE:                 begin x_o = ~a_i; cin_sel = CIN_CA; end
      OP_ADDME:                 begin y_o = '1; cin_sel = CIN_CA; end
      OP_SUBFME:                begin x_o = ~a_i; y_o = '1; cin_sel = CIN_CA; end
      OP_ADDZE:                 begin y_o = '0; cin_sel = CIN_CA; end
      OP_SUBFZE:                begin x_o = ~a_i; y_o = '0; cin_sel = CIN_CA; end
      OP_NEG:                   begin x_o = ~a_i; y_o = '0; cin_sel = CIN_ONE; end
      OP_ADDI:                  begin x_o = a_or_zero; y_o = imm_sx; end
      OP_ADDIS:                 begin x_o = a_or_zero; y_o = imm_sh; end
      OP_ADDPCIS:               begin x_o = nia_i; y_o = imm_sh; end
      OP_ADDIC, OP_ADDIC_RC:    y_o = imm_sx;
      OP_SUBFIC:                begin x_o = ~a_i; y_o = imm_sx; cin_sel = CIN_ONE; end
      OP_ADDEX:                 cin_sel = CIN_OV;
      default:                  begin x_o = '0; y_o = '0; legal_o = 1'b0; end
    endcase
  end

  always_comb begin
    unique case (cin_sel)
      CIN_ONE: cin_o = 1'b1;
      CIN_CA:  cin_o = ca_i;
      CIN_OV:  cin_o = ov_i;
      default: cin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/add_sub_chain.sv
module add_sub_chain #(
  parameter int W   = 64,
  parameter int BLK = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int NBLK = W / BLK;

  logic [NBLK:0] c;
  assign c[0] = cin_i;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    logic [BLK:0] part;
    assign part = {1'b0, x_i[g*BLK +: BLK]} + {1'b0, y_i[g*BLK +: BLK]} + {{BLK{1'b0}}, c[g]};
    assign sum_o[g*BLK +: BLK] = part[BLK-1:0];
    assign c[g+1] = part[BLK];
  end

  assign cout_o = c[NBLK];
endmodule

// File: rtl/add_sub_flags.sv
module add_sub_flags
  import add_sub_pkg::*;
#(
  parameter int W = XLEN
) (
  input  op_e          op_i,
  input  logic         legal_i,
  input  logic         oe_i,
  input  logic         rc_i,
  input  logic [W-1:0] sum_i,
  input  logic         x_msb_i,
  input  logic         y_msb_i,
  input  logic         cout_i,
  input  logic         ca_i,
  input  logic         ov_i,
  input  logic         so_q_i,
  output logic         ca_o,
  output logic         ov_o,
  output logic         so_set_o,
  output logic [3:0]   cond_o
);
  logic sgn_ovf, rec_ov, rec_cr, lt, eq;

  assign sgn_ovf  = (x_msb_i == y_msb_i) && (sum_i[W-1] != x_msb_i);
  assign rec_ov   = legal_i && is_reg_form(op_i) && oe_i;
  assign rec_cr   = legal_i && ((is_reg_form(op_i) && rc_i) || op_i == OP_ADDIC_RC);
  assign so_set_o = rec_ov && sgn_ovf;

  assign ca_o = (legal_i && writes_ca(op_i)) ? cout_i : ca_i;

  always_comb begin
    if (legal_i && op_i == OP_ADDEX) ov_o = cout_i;
    else if (rec_ov)                 ov_o = sgn_ovf;
    else                             ov_o = ov_i;
  end

  assign lt     = sum_i[W-1];
  assign eq     = (sum_i == '0);
  assign cond_o = rec_cr ? {lt, !lt && !eq, eq, so_q_i | so_set_o} : 4'b0;
endmodule

// File: rtl/add_sub_unit.sv
module add_sub_unit
  import add_sub_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int IW  = IMM_W,
  parameter int BLK = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exec_i,
  input  logic [4:0]    op_i,
  input  logic          oe_i,
  input  logic          rc_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [IW-1:0] imm_i,
  input  logic          ra_zero_i,
  input  logic [W-1:0]  nia_i,
  input  logic          ca_i,
  input  logic          ov_i,
  output logic [W-1:0]  res_o,
  output logic          ca_o,
  output logic          ov_o,
  output logic          so_o,
  output logic [3:0]    cond_o
);
  op_e          op;
  logic [W-1:0] x, y, sum;
  logic         cin, cout, legal, so_set, so_q;

  assign op = op_e'(op_i);

  add_sub_opsel #(.W(W), .IW(IW)) u_opsel (
    .op_i(op), .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .ra_zero_i(ra_zero_i),
    .nia_i(nia_i), .ca_i(ca_i), .ov_i(ov_i),
    .x_o(x), .y_o(y), .cin_o(cin), .legal_o(legal)
  );

  add_sub_chain #(.W(W), .BLK(BLK)) u_chain (
    .x_i(x), .y_i(y), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  add_sub_flags #(.W(W)) u_flags (
    .op_i(op), .legal_i(legal), .oe_i(oe_i), .rc_i(rc_i), .sum_i(sum),
    .x_msb_i(x[W-1]), .y_msb_i(y[W-1]), .cout_i(cout),
    .ca_i(ca_i), .ov_i(ov_i), .so_q_i(so_q),
    .ca_o(ca_o), .ov_o(ov_o), .so_set_o(so_set), .cond_o(cond_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               so_q <= 1'b0;
    else if (exec_i && so_set) so_q <= 1'b1;
  end

  assign res_o = legal ? sum : '0;
  assign so_o  = so_q;
endmodule

// File: rtl/add_sub_unit_chk.sv
module add_sub_unit_chk #(
  parameter int W  = 64,
  parameter int IW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          exec_i,
  input logic [4:0]    op_i,
  input logic          oe_i,
  input logic          rc_i,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [IW-1:0] imm_i,
  input logic          ra_zero_i,
  input logic [W-1:0]  nia_i,
  input logic          ca_i,
  input logic          ov_i,
  input logic [W-1:0]  res_o,
  input logic          ca_o,
  input logic          ov_o,
  input logic          so_o,
  input logic [3:0]    cond_o
);
  logic reg_form;
  assign reg_form = (op_i <= 5'd10);

  AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 5'd0 |-> res_o == a_i + b_i); // R1
  AST_ADDEX_CA_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 5'd17 |-> ca_o == ca_i); // R6
  AST_OV_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_i && op_i != 5'd17) |-> ov_o == ov_i); // R7
  AST_SO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && oe_i && reg_form && ov_o) |=> so_o); // R8
  AST_SO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_o |=> so_o); // R8
  AST_COND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(reg_form && rc_i) && op_i != 5'd15) |-> cond_o == 4'b0); // R9
  AST_COND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_form && rc_i) |-> $countones(cond_o[3:1]) == 1); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i > 5'd17 |-> (res_o == '0 && ca_o == ca_i)); // R10
endmodule

bind add_sub_unit add_sub_unit_chk #(.W(W), .IW(IW)) u_chk (.*);

// File: tb/add_sub_unit_bench.sv
`timescale 1ns/1ps
module add_sub_unit_bench;
  logic        clk = 1'b0, rst_ni = 1'b0, exec = 1'b0;
  logic [4:0]  op = '0;
  logic        oe = 1'b0, rc = 1'b0, raz = 1'b0, ca = 1'b0, ov = 1'b0;
  logic [63:0] a = '0, b = '0, nia = '0;
  logic [15:0] imm = '0;
  logic [63:0] res;
  logic        ca_o, ov_o, so_o;
  logic [3:0]  cond;

  int n_chk = 0, n_err = 0;
  logic so_m = 1'b0;

  always #2.5 clk = ~clk;

  add_sub_unit u_add_sub_unit (
    .clk_i(clk), .rst_ni(rst_ni), .exec_i(exec), .op_i(op), .oe_i(oe), .rc_i(rc),
    .a_i(a), .b_i(b), .imm_i(imm), .ra_zero_i(raz), .nia_i(nia), .ca_i(ca), .ov_i(ov),
    .res_o(res), .ca_o(ca_o), .ov_o(ov_o), .so_o(so_o), .cond_o(cond)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirement text.
  task automatic run(string tag, logic [4:0] o, logic e_oe, logic e_rc,
                     logic [63:0] va, logic [63:0] vb, logic [15:0] vi,
                     logic vraz, logic [63:0] vn, logic vca, logic vov);
    logic [63:0] x, y, sx, sh, er;
    logic [64:0] s;
    logic cin, eca, eov, ovf, legal, regf, rec_cr, eso;
    logic [3:0] ec;
    sx = {{48{vi[15]}}, vi};
    sh = {{32{vi[15]}}, vi, 16'h0};
    x = va; y = vb; cin = 1'b0; legal = 1'b1;
    case (o)
      0, 2:   ;
      1, 3:   begin x = ~va; cin = 1; end
      4:      cin = vca;
      5:      begin x = ~va; cin = vca; end
      6:      begin y = '1; cin = vca; end
      7:      begin x = ~va; y = '1; cin = vca; end
      8:      begin y = '0; cin = vca; end
      9:      begin x = ~va; y = '0; cin = vca; end
      10:     begin x = ~va; y = '0; cin = 1; end
      11:     begin x = vraz ? '0 : va; y = sx; end
      12:     begin x = vraz ? '0 : va; y = sh; end
      13:     begin x = vn; y = sh; end
      14, 15: y = sx;
      16:     begin x = ~va; y = sx; cin = 1; end
      17:     cin = vov;
      default: begin x = '0; y = '0; legal = 0; end
    endcase
    s   = {1'b0, x} + {1'b0, y} + {64'b0, cin};
    er  = legal ? s[63:0] : '0;
    regf = (o <= 10);
    ovf = (x[63] == y[63]) && (s[63] != x[63]);
    eca = ((o >= 2 && o <= 9) || (o >= 14 && o <= 16)) ? s[64] : vca;
    if (o == 17)            eov = s[64];
    else if (regf && e_oe)  eov = ovf;
    else                    eov = vov;
    eso = regf && e_oe && ovf;
    rec_cr = (regf && e_rc) || o == 15;
    ec = rec_cr ? {er[63], !er[63] && er != 0, er == 0, so_m | eso} : 4'b0;

    @(negedge clk);
    exec = 1; op = o; oe = e_oe; rc = e_rc; a = va; b = vb; imm = vi;
    raz = vraz; nia = vn; ca = vca; ov = vov;
    #1;
    chk({tag, " res"},  res, er);
    chk({tag, " ca"},   {63'b0, ca_o}, {63'b0, eca});
    chk({tag, " ov"},   {63'b0, ov_o}, {63'b0, eov});
    chk({tag, " cond"}, {60'b0, cond}, {60'b0, ec});
    chk({tag, " so"},   {63'b0, so_o}, {63'b0, so_m});
    @(posedge clk);
    so_m = so_m | eso;
    #0.1 exec = 0;
  endtask

  task automatic t_reset();
    chk("R8 reset so", {63'b0, so_o}, 64'd0);
  endtask

  task automatic t_basic(); // R1
    run("R1 add",    0, 0, 0, 64'd5, 64'd7, 0, 0, 0, 0, 0);
    run("R1 subf",   1, 0, 0, 64'd10, 64'd3, 0, 0, 0, 1, 0);
    run("R1 neg",    10, 0, 0, 64'd1, 64'd0, 0, 0, 0, 0, 0);
    run("R1 neg0",   10, 0, 0, 64'd0, 64'd0, 0, 0, 0, 1, 0);
    run("R1 subfic", 16, 0, 0, 64'd4, 0, 16'hFFFE, 0, 0, 0, 0);
    run("R1 addic",  14, 0, 0, 64'd3, 0, 16'h8000, 1, 0, 0, 0);
  endtask

  task automatic t_imm(); // R2 R3
    run("R2 addi raz",   11, 0, 0, 64'hDEAD, 0, 16'hFFF0, 1, 0, 0, 0);
    run("R2 addi a",     11, 0, 0, 64'hDEAD, 0, 16'h0010, 0, 0, 0, 0);
    run("R2 addis raz",  12, 0, 0, 64'h1234, 0, 16'h8001, 1, 0, 0, 0);
    run("R2 addis a",    12, 0, 0, 64'h1234, 0, 16'h0001, 0, 0, 0, 0);
    run("R3 addpcis",    13, 0, 0, 64'h99, 0, 16'hFFFF, 1, 64'h0000_0000_0010_0004, 0, 0);
  endtask

  task automatic t_ext(); // R4 R5
    run("R4 adde ca1",   4, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, 0, 1, 0);
    run("R4 subfe ca0",  5, 0, 0, 64'd3, 64'd10, 0, 0, 0, 0, 0);
    run("R4 addme",      6, 0, 0, 64'd0, 0, 0, 0, 0, 0, 0);
    run("R4 subfme",     7, 0, 0, 64'd5, 0, 0, 0, 0, 1, 0);
    run("R4 addze",      8, 0, 0, 64'd9, 0, 0, 0, 0, 1, 0);
    run("R4 subfze",     9, 0, 0, 64'd0, 0, 0, 0, 0, 1, 0);
    run("R5 addc cout",  2, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0);
    run("R5 subfc",      3, 0, 0, 64'd7, 64'd2, 0, 0, 0, 1, 0);
    run("R5 add keep",   0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_alt(); // R6
    run("R6 addex ov1",  17, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, 0, 1, 1);
    run("R6 addex ov0",  17, 1, 0, 64'd2, 64'd3, 0, 0, 0, 0, 0);
  endtask

  task automatic t_ovf(); // R7 R8 R9
    run("R7 ovf oe0",   0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 1);
    run("R7 addi oe",   11, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 0, 16'h0001, 0, 0, 0, 0);
    run("R9 cond neg",  1, 0, 1, 64'd5, 64'd2, 0, 0, 0, 0, 0);
    run("R9 cond zero", 0, 0, 1, 64'd0, 64'd0, 0, 0, 0, 0, 0);
    run("R9 rec imm",   15, 0, 0, 64'd1, 0, 16'd1, 0, 0, 0, 0);
    run("R9 rc ignored imm", 14, 0, 1, 64'd1, 0, 16'd1, 0, 0, 0, 0);
    run("R8 ovf rec",   0, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0);
    run("R8 sticky",    0, 1, 1, 64'd1, 64'd1, 0, 0, 0, 0, 0);
    run("R7 subf ovf",  1, 1, 0, 64'd1, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_illegal(); // R10
    run("R10 op18", 18, 1, 1, 64'h55, 64'h66, 16'h7, 0, 0, 1, 1);
    run("R10 op31", 31, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset();
        #10 rst_ni = 1'b1;
        t_basic();
        t_imm();
        t_ext();
        t_alt();
        t_ovf();
        t_illegal();
        @(negedge clk);
        chk("R8 so held", {63'b0, so_o}, 64'd1);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule